// File: doc/BRIEF.md
# Reset Strap Capture and Override

This block gives the rest of the chip a fixed copy of the board-level configuration straps. After the active-low hard reset is released, the block waits a fixed settle window. It then latches every strap at once and from that point ignores the strap pins. The captured values supply the I2C slave address, the boot EEPROM address, the EEPROM addressing mode and the enable for the boot-time register load. They also supply the initial width and link speed of each serial port.

For one cycle after the capture, a pulse tells the EEPROM loader that the values are valid. The load-disable strap must stay still during the window. If it moves, a sticky flag records this, and the value present at the end of the window is the one used.

Software can then take over width and speed for each port through a small write port. Each of those fields has its own enable bit. The same write port sets per-port power-down controls for the single-lane and four-lane modes.

Top module: `strap_latch`

## Requirements
- R1: While `rst_n` is low, `sampled_valid`, `strap_unstable`, `boot_load_en`, `multibyte_mode`, every width bit and every power-down bit are 0, and every port speed reads the default code 2'b11. All override registers are cleared.
- R2: The straps are captured on the SETTLE-th (default 10th) rising clock edge after `rst_n` rises. `sampled_valid` is high for exactly the one cycle that follows that edge.
- R3: After capture, `slave_addr` equals {SLV_UPPER, sa[1:0]}, where `sa` is the captured value of `strap_sa`.
- R4: After capture, `eeprom_addr` equals {EE_UPPER, sa[1:0]} when the captured `strap_pin_sel` is 1, and {EE_UPPER, 2'b00} when it is 0.
- R5: After capture, `multibyte_mode` equals the captured `strap_multibyte` (1 = multi-byte addressing). `boot_load_en` is 1 only if capture has taken place and the captured `strap_load_dis` is 0.
- R6: After capture, changes on any strap input have no effect on any output.
- R7: If `strap_load_dis` differs between two consecutive rising edges inside the window (edges 1 to SETTLE), `strap_unstable` becomes 1 and stays 1 until reset. The value sampled at edge SETTLE is used.
- R8: Bit i of `port_width` (1 = four-lane, 0 = single-lane) is the captured `strap_width[i]`, unless the width override of port i is enabled, in which case it is the override value.
- R9: Bits [2i+1:2i] of `port_speed` are the captured `strap_speed` (2'b11 = 3.125 Gbit/s default), unless the speed override of port i is enabled, in which case they are the override code.
- R10: `port_pd_x1[i]` and `port_pd_x4[i]` show the power-down fields last written to port i. Both are 0 after reset.
- R11: A write with `ovr_we` high updates only the port selected by `ovr_port`, and the outputs show the new values in the cycle after the write edge. Clearing an enable returns that field to the captured strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| strap_multibyte | input | 1 | Multi-byte EEPROM addressing strap |
| strap_sa | input | 2 | Low two slave-address bits strap |
| strap_pin_sel | input | 1 | Use `strap_sa` in the EEPROM address |
| strap_load_dis | input | 1 | 1 = skip boot register load |
| strap_width | input | NUM_PORTS | Initial width per port, 1 = four-lane |
| strap_speed | input | 2 | Initial link speed code |
| ovr_we | input | 1 | Override write strobe |
| ovr_port | input | PIDX_W | Port selected by the write |
| ovr_width_en | input | 1 | Enable for the width override |
| ovr_width | input | 1 | Width override value |
| ovr_speed_en | input | 1 | Enable for the speed override |
| ovr_speed | input | 2 | Speed override code |
| ovr_pd_x1 | input | 1 | Single-lane power-down value |
| ovr_pd_x4 | input | 1 | Four-lane power-down value |
| slave_addr | output | 7 | I2C slave address |
| eeprom_addr | output | 7 | Boot EEPROM address |
| boot_load_en | output | 1 | Boot register load enabled |
| multibyte_mode | output | 1 | Multi-byte EEPROM addressing |
| port_width | output | NUM_PORTS | Effective width per port |
| port_speed | output | 2*NUM_PORTS | Effective speed code per port |
| port_pd_x1 | output | NUM_PORTS | Single-lane power-down per port |
| port_pd_x4 | output | NUM_PORTS | Four-lane power-down per port |
| sampled_valid | output | 1 | One-cycle pulse after capture |
| strap_unstable | output | 1 | Sticky: load-disable strap moved in the window |

## Verification
The hardest situation to reach is a load-disable strap that moves inside the settle window. The normal flow holds the straps still through reset, so this needs deliberate stimulus. The bench releases reset and counts edges from the release. It toggles the strap between chosen edges inside the window, and in a separate run changes it just after the capture edge. This shows that the flag and the captured value depend on edge position and not merely on the strap having changed. Every strap combination goes through a full reset-and-capture cycle, so all address compositions and mode bits are covered.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam logic [1:0] SPEED_DEFAULT = 2'b11;

  function automatic logic [6:0] make_slave_addr(input logic [4:0] upper, input logic [1:0] sa);
    return {upper, sa};
  endfunction

  function automatic logic [6:0] make_eeprom_addr(input logic [4:0] upper, input logic [1:0] sa,
                                                  input logic use_pins);
    return {upper, (use_pins ? sa : 2'b00)};
  endfunction
endpackage

// File: rtl/strap_window.sv
module strap_window #(
  parameter int SETTLE = 10,
  parameter int DW = 4,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          dis_in,
  output logic [DW-1:0] cap_q,
  output logic          dis_q,
  output logic          done,
  output logic          valid_pulse,
  output logic          unstable
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

  logic [CNT_W-1:0] cnt;
  logic             dis_prev;
  logic             capture_now;
  logic             dis_moved;

  assign capture_now = !done && (cnt == LAST);
  assign dis_moved   = !done && (cnt != '0) && (dis_in != dis_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      done        <= 1'b0;
      valid_pulse <= 1'b0;
      unstable    <= 1'b0;
      dis_prev    <= 1'b0;
      cap_q       <= RST_VAL;
      dis_q       <= 1'b0;
    end else begin
      valid_pulse <= capture_now;
      if (!done) begin
        cnt      <= cnt + 1'b1;
        dis_prev <= dis_in;
      end
      if (dis_moved) unstable <= 1'b1;
      if (capture_now) begin
        done  <= 1'b1;
        cap_q <= din;
        dis_q <= dis_in;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse |=> (!valid_pulse && done));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(cap_q) && $stable(dis_q) && done));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unstable |=> unstable);
endmodule

// File: rtl/strap_port_ovr.sv
module strap_port_ovr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       width_en,
  input  logic       width,
  input  logic       speed_en,
  input  logic [1:0] speed,
  input  logic       pd_x1_in,
  input  logic       pd_x4_in,
  input  logic       cap_width,
  input  logic [1:0] cap_speed,
  output logic       eff_width,
  output logic [1:0] eff_speed,
  output logic       pd_x1,
  output logic       pd_x4
);
  logic       w_en_q, w_q, s_en_q;
  logic [1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_en_q <= 1'b0;
      w_q    <= 1'b0;
      s_en_q <= 1'b0;
      s_q    <= 2'b00;
      pd_x1  <= 1'b0;
      pd_x4  <= 1'b0;
    end else if (we) begin
      w_en_q <= width_en;
      w_q    <= width;
      s_en_q <= speed_en;
      s_q    <= speed;
      pd_x1  <= pd_x1_in;
      pd_x4  <= pd_x4_in;
    end
  end

  assign eff_width = w_en_q ? w_q : cap_width;
  assign eff_speed = s_en_q ? s_q : cap_speed;

  a_r8_width_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && width_en) |=> (eff_width == $past(width)));
  a_r9_speed_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && speed_en) |=> (eff_speed == $past(speed)));
  a_r10_pd_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (pd_x1 == $past(pd_x1_in) && pd_x4 == $past(pd_x4_in)));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int SETTLE = 10,
  parameter int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter logic [4:0] SLV_UPPER = 5'b10110,
  parameter logic [4:0] EE_UPPER = 5'b10100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_multibyte,
  input  logic [1:0]             strap_sa,
  input  logic                   strap_pin_sel,
  input  logic                   strap_load_dis,
  input  logic [NUM_PORTS-1:0]   strap_width,
  input  logic [1:0]             strap_speed,
  input  logic                   ovr_we,
  input  logic [PIDX_W-1:0]      ovr_port,
  input  logic                   ovr_width_en,
  input  logic                   ovr_width,
  input  logic                   ovr_speed_en,
  input  logic [1:0]             ovr_speed,
  input  logic                   ovr_pd_x1,
  input  logic                   ovr_pd_x4,
  output logic [6:0]             slave_addr,
  output logic [6:0]             eeprom_addr,
  output logic                   boot_load_en,
  output logic                   multibyte_mode,
  output logic [NUM_PORTS-1:0]   port_width,
  output logic [2*NUM_PORTS-1:0] port_speed,
  output logic [NUM_PORTS-1:0]   port_pd_x1,
  output logic [NUM_PORTS-1:0]   port_pd_x4,
  output logic                   sampled_valid,
  output logic                   strap_unstable
);
  // capture layout: {speed, width, pin_sel, sa, multibyte}
  localparam int CAP_W = 2 + NUM_PORTS + 1 + 2 + 1;
  localparam logic [CAP_W-1:0] CAP_RST = {SPEED_DEFAULT, {(CAP_W-2){1'b0}}};

  logic [CAP_W-1:0]     cap_vec;
  logic                 cap_dis;
  logic                 cap_done;
  logic                 cap_mb, cap_sel;
  logic [1:0]           cap_sa, cap_speed;
  logic [NUM_PORTS-1:0] cap_width;

  strap_window #(.SETTLE(SETTLE), .DW(CAP_W), .RST_VAL(CAP_RST)) u_win (
    .clk(clk), .rst_n(rst_n),
    .din({strap_speed, strap_width, strap_pin_sel, strap_sa, strap_multibyte}),
    .dis_in(strap_load_dis),
    .cap_q(cap_vec), .dis_q(cap_dis), .done(cap_done),
    .valid_pulse(sampled_valid), .unstable(strap_unstable)
  );

  assign cap_mb    = cap_vec[0];
  assign cap_sa    = cap_vec[2:1];
  assign cap_sel   = cap_vec[3];
  assign cap_width = cap_vec[4 +: NUM_PORTS];
  assign cap_speed = cap_vec[CAP_W-1 -: 2];

  assign slave_addr     = make_slave_addr(SLV_UPPER, cap_sa);
  assign eeprom_addr    = make_eeprom_addr(EE_UPPER, cap_sa, cap_sel);
  assign multibyte_mode = cap_mb;
  assign boot_load_en   = cap_done && !cap_dis;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic sel_we;
    assign sel_we = ovr_we && (ovr_port == PIDX_W'(i));
    strap_port_ovr u_ovr (
      .clk(clk), .rst_n(rst_n), .we(sel_we),
      .width_en(ovr_width_en), .width(ovr_width),
      .speed_en(ovr_speed_en), .speed(ovr_speed),
      .pd_x1_in(ovr_pd_x1), .pd_x4_in(ovr_pd_x4),
      .cap_width(cap_width[i]), .cap_speed(cap_speed),
      .eff_width(port_width[i]), .eff_speed(port_speed[2*i +: 2]),
      .pd_x1(port_pd_x1[i]), .pd_x4(port_pd_x4[i])
    );
  end

  a_r4_eeprom_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !cap_sel) |-> (eeprom_addr[1:0] == 2'b00));
  a_r5_load_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    boot_load_en |-> cap_done);
  a_r3_slave_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_done) |-> (slave_addr[1:0] == $past(strap_sa)));
endmodule

// File: tb/sim_strap_latch.sv
module sim_strap_latch;
  localparam int NP = 2;
  localparam int SETTLE = 10;
  localparam logic [4:0] SU = 5'b10110;
  localparam logic [4:0] EU = 5'b10100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mb = 0, sel = 0, dis = 0;
  logic [1:0] sa = 0, spd = 0;
  logic [NP-1:0] wid = 0;
  logic we = 0, w_en = 0, w_v = 0, s_en = 0, px1 = 0, px4 = 0;
  logic [0:0] oport = 0;
  logic [1:0] s_v = 0;
  logic [6:0] slave_addr, eeprom_addr;
  logic boot_load_en, multibyte_mode, sampled_valid, strap_unstable;
  logic [NP-1:0] port_width, port_pd_x1, port_pd_x4;
  logic [2*NP-1:0] port_speed;

  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  strap_latch #(.NUM_PORTS(NP), .SETTLE(SETTLE), .SLV_UPPER(SU), .EE_UPPER(EU)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_multibyte(mb), .strap_sa(sa), .strap_pin_sel(sel),
    .strap_load_dis(dis), .strap_width(wid), .strap_speed(spd),
    .ovr_we(we), .ovr_port(oport), .ovr_width_en(w_en), .ovr_width(w_v),
    .ovr_speed_en(s_en), .ovr_speed(s_v), .ovr_pd_x1(px1), .ovr_pd_x4(px4),
    .slave_addr(slave_addr), .eeprom_addr(eeprom_addr), .boot_load_en(boot_load_en),
    .multibyte_mode(multibyte_mode), .port_width(port_width), .port_speed(port_speed),
    .port_pd_x1(port_pd_x1), .port_pd_x4(port_pd_x4),
    .sampled_valid(sampled_valid), .strap_unstable(strap_unstable)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_port(input int p, input logic we_w, input logic wv, input logic se,
                            input logic [1:0] sv, input logic p1, input logic p4);
    oport = 1'(p); w_en = we_w; w_v = wv; s_en = se; s_v = sv; px1 = p1; px4 = p4;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // drive straps s = {spd, wid, dis, sel, sa, mb}, reset, release, check capture
  task automatic run_capture(input logic [8:0] s);
    logic [6:0] exp_sl, exp_ee;
    do_reset();
    mb = s[0]; sa = s[2:1]; sel = s[3]; dis = s[4]; wid = s[6:5]; spd = s[8:7];
    if (s == 9'd0) begin
      chk(sampled_valid == 0 && strap_unstable == 0 && boot_load_en == 0, "R1 reset flags",
          {sampled_valid, strap_unstable, boot_load_en}, 0);
      chk(port_speed == 4'b1111 && port_width == 0 && multibyte_mode == 0, "R1 reset port state",
          {port_speed, port_width, multibyte_mode}, {4'b1111, 2'b00, 1'b0});
      chk(port_pd_x1 == 0 && port_pd_x4 == 0, "R1 reset power-down", {port_pd_x1, port_pd_x4}, 0);
    end
    rst_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    chk(sampled_valid == 0 && boot_load_en == 0, "R2 no capture before edge SETTLE",
        {sampled_valid, boot_load_en}, 0);
    @(negedge clk);
    exp_sl = {SU, s[2:1]};
    exp_ee = {EU, (s[3] ? s[2:1] : 2'b00)};
    chk(sampled_valid == 1, "R2 pulse after capture edge", sampled_valid, 1);
    chk(slave_addr == exp_sl, "R3 slave address", slave_addr, exp_sl);
    chk(eeprom_addr == exp_ee, "R4 eeprom address", eeprom_addr, exp_ee);
    chk(multibyte_mode == s[0], "R5 multibyte mode", multibyte_mode, s[0]);
    chk(boot_load_en == !s[4], "R5 boot load enable", boot_load_en, !s[4]);
    chk(port_width == s[6:5], "R8 captured width", port_width, s[6:5]);
    chk(port_speed == {s[8:7], s[8:7]}, "R9 captured speed", port_speed, {s[8:7], s[8:7]});
    chk(strap_unstable == 0, "R7 stable strap no flag", strap_unstable, 0);
    @(negedge clk);
    chk(sampled_valid == 0, "R2 pulse one cycle", sampled_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int s = 0; s < 512; s++) run_capture(9'(s));

    // R6: strap changes after capture are ignored
    run_capture(9'b10_01_0_1_10_1);
    mb = 0; sa = 2'b01; sel = 0; dis = 1; wid = 2'b10; spd = 2'b00;
    repeat (4) @(negedge clk);
    chk(slave_addr == {SU, 2'b10} && eeprom_addr == {EU, 2'b10}, "R6 addresses held",
        {slave_addr, eeprom_addr}, {SU, 2'b10, EU, 2'b10});
    chk(multibyte_mode == 1 && boot_load_en == 1, "R6 modes held", {multibyte_mode, boot_load_en}, 2'b11);
    chk(port_width == 2'b01 && port_speed == 4'b1010, "R6 port state held",
        {port_width, port_speed}, {2'b01, 4'b1010});
    chk(strap_unstable == 0 && sampled_valid == 0, "R6 no flag after window",
        {strap_unstable, sampled_valid}, 0);

    // R7: disable strap toggles inside the window, ends at 1
    do_reset();
    dis = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    dis = 1'b1;
    repeat (SETTLE - 4) @(negedge clk);
    chk(strap_unstable == 1, "R7 flag set", strap_unstable, 1);
    chk(boot_load_en == 0, "R7 final value used", boot_load_en, 0);
    repeat (5) @(negedge clk);
    chk(strap_unstable == 1, "R7 flag sticky", strap_unstable, 1);

    // R7: toggle between edge SETTLE-1 and SETTLE, back to 0
    do_reset();
    dis = 1'b1;
    rst_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    dis = 1'b0;
    @(negedge clk);
    chk(strap_unstable == 1 && boot_load_en == 1, "R7 late toggle in window",
        {strap_unstable, boot_load_en}, 2'b11);
    do_reset();
    chk(strap_unstable == 0, "R1 reset clears flag", strap_unstable, 0);

    // R8-R11: overrides
    run_capture(9'b01_10_0_0_00_0);
    write_port(0, 1, 1, 0, 2'b00, 1, 0);
    chk(port_width == 2'b11, "R8 port0 width override", port_width, 2'b11);
    chk(port_speed == 4'b0101, "R11 port0 speed untouched", port_speed, 4'b0101);
    chk(port_pd_x1 == 2'b01 && port_pd_x4 == 2'b00, "R10 port0 pd", {port_pd_x1, port_pd_x4}, 4'b0100);
    write_port(1, 1, 0, 1, 2'b11, 0, 1);
    chk(port_width == 2'b01, "R8 port1 width override", port_width, 2'b01);
    chk(port_speed == 4'b1101, "R9 port1 speed override", port_speed, 4'b1101);
    chk(port_pd_x1 == 2'b01 && port_pd_x4 == 2'b10, "R10 port1 pd", {port_pd_x1, port_pd_x4}, 4'b0110);
    write_port(1, 0, 1, 0, 2'b00, 0, 0);
    chk(port_width == 2'b11 && port_speed == 4'b0101, "R11 enable cleared returns strap",
        {port_width, port_speed}, {2'b11, 4'b0101});
    chk(port_pd_x4 == 2'b00, "R10 pd cleared", port_pd_x4, 0);
    // R11: timing, new value not visible before the write edge
    oport = 1'b0; w_en = 1'b1; w_v = 1'b0; s_en = 1'b1; s_v = 2'b10; px1 = 0; px4 = 0;
    we = 1'b1;
    #1;
    chk(port_width[0] == 1'b1, "R11 no change before edge", port_width[0], 1);
    @(negedge clk);
    we = 1'b0;
    chk(port_width == 2'b10 && port_speed == 4'b0110, "R11 change after edge",
        {port_width, port_speed}, {2'b10, 4'b0110});
    do_reset();
    chk(port_width == 0 && port_speed == 4'b1111 && port_pd_x1 == 0, "R1 reset clears overrides",
        {port_width, port_speed, port_pd_x1}, {2'b00, 4'b1111, 2'b00});

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule